// File: doc/BRIEF.md
# Wire Hit Age LUT Addresser

This block keeps track of how recently each wire in a group of eight drift-chamber wires has fired. On every base trigger tick it takes one binary hit bit per wire. It keeps a saturating 2-bit age counter for each wire. The eight counters together form a 16-bit address into a segment lookup memory. One of the eight wires is the pivot wire, which belongs to this group alone. The other seven are shared with neighbouring groups, so the block handles all eight the same way.

After every tick, the new address is presented to the lookup memory through a plain read port: a one-cycle read strobe plus the address. The memory answers with a fixed latency of one clock. The block then outputs the returned word together with the address that produced it and a valid flag. A mode input sets what happens when a wire fires again while its previous hit is still recent. In restart mode the age goes back to zero. In keep mode the older age keeps counting and the new hit is dropped.

Top module: `hit_age_addresser`

## Requirements
- R1: While reset is asserted and right after it is released, every age counter is 3, so `lut_addr_o` is 16'hFFFF, and both `lut_rd_en_o` and `seg_valid_o` are 0.
- R2: A hit on a wire during a tick, when that wire's age is 3, sets its age to 0. This happens in either mode.
- R3: During a tick without a hit, a wire's age increases by 1 and stays at 3 once it gets there.
- R4: When `tick_i` is 0, hit inputs have no effect, every age and `lut_addr_o` hold their values, and no read is issued.
- R5: With `rehit_mode_i` = 0 (restart), a hit during a tick on a wire whose age is 0, 1 or 2 sets that age to 0.
- R6: With `rehit_mode_i` = 1 (keep older), a hit during a tick on a wire whose age is 0, 1 or 2 is dropped, and the age increases by 1 as if there were no hit.
- R7: `lut_addr_o` is made of the eight ages, with wire i in bits [2i+1:2i]. Wire 0 is in the least significant pair and wire 7 in the most significant pair. It shows the ages as updated by the most recent tick.
- R8: `lut_rd_en_o` is 1 for exactly the one clock after each clock in which `tick_i` is 1, and 0 otherwise.
- R9: Two clocks after each read strobe, `seg_valid_o` is 1 for one clock. At that point `seg_addr_o` holds the address that was read and `seg_word_o` holds the word the memory returned for it one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base trigger tick enable |
| hit_i | input | 8 | One hit bit per wire, sampled when tick_i is 1 |
| rehit_mode_i | input | 1 | Repeat-hit rule: 0 restart, 1 keep older age |
| lut_rd_en_o | output | 1 | Lookup memory read strobe |
| lut_addr_o | output | 16 | Lookup address (packed wire ages) |
| lut_rd_data_i | input | 16 | Lookup memory read data, one clock after the strobe |
| seg_valid_o | output | 1 | Returned segment word valid |
| seg_addr_o | output | 16 | Address that produced seg_word_o |
| seg_word_o | output | 16 | Segment word returned by the memory |

## Verification
The hardest case to reach is a repeat hit on a wire whose age is still 1 or 2 in keep mode. It needs a hit, then at least one quiet tick, then a second hit, all on the same wire with the mode held. The stimulus builds this sequence in directed form and then checks that the age runs on to 3 and restarts only on the next hit. A long random phase follows with sparse hits, gaps between ticks and mode changes. This covers back-to-back ticks while a read is still in flight and repeat hits in both modes.

// File: rtl/hit_age_pkg.sv
package hit_age_pkg;

    typedef enum logic {
        REHIT_RESTART = 1'b0,
        REHIT_KEEP    = 1'b1
    } rehit_mode_e;

endpackage

// File: rtl/hit_age_cell.sv
module hit_age_cell
    import hit_age_pkg::*;
#(
    parameter int unsigned AGE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hit_i,
    input  rehit_mode_e      mode_i,
    output logic [AGE_W-1:0] age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] age_d;
    logic [AGE_W-1:0] age_q;

    always_comb begin
        age_d = age_q;
        if (tick_i) begin
            if (hit_i && (mode_i == REHIT_RESTART || age_q == AGE_MAX)) begin
                age_d = '0;
            end else if (age_q != AGE_MAX) begin
                age_d = age_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= AGE_MAX;
        end else begin
            age_q <= age_d;
        end
    end

    assign age_o = age_q;

    // R2: a fresh hit on an idle wire starts the age at zero
    a_r2_fresh_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i && age_q == AGE_MAX) |=> (age_q == '0));

    // R3: quiet tick saturates at the top value
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !hit_i && age_q == AGE_MAX) |=> (age_q == AGE_MAX));

    // R4: no tick, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(age_q));

    // R5: restart rule
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i && mode_i == REHIT_RESTART) |=> (age_q == '0));

    // R6: keep-older rule
    a_r6_keep_older: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i && mode_i == REHIT_KEEP && age_q != AGE_MAX)
        |=> (age_q == AGE_W'($past(age_q) + 1'b1)));

endmodule

// File: rtl/lut_read_pipe.sv
module lut_read_pipe #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rd_en_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              seg_valid_o,
    output logic [ADDR_W-1:0] seg_addr_o,
    output logic [WORD_W-1:0] seg_word_o
);

    typedef struct packed {
        logic              rd_v;
        logic              ret_v;
        logic [ADDR_W-1:0] ret_addr;
        logic              seg_v;
        logic [ADDR_W-1:0] seg_addr;
        logic [WORD_W-1:0] seg_word;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rd_v  = tick_i;
        st_d.ret_v = st_q.rd_v;
        if (st_q.rd_v) begin
            st_d.ret_addr = addr_i;
        end
        st_d.seg_v = st_q.ret_v;
        if (st_q.ret_v) begin
            st_d.seg_addr = st_q.ret_addr;
            st_d.seg_word = rd_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en_o     = st_q.rd_v;
    assign seg_valid_o = st_q.seg_v;
    assign seg_addr_o  = st_q.seg_addr;
    assign seg_word_o  = st_q.seg_word;

    // R9: read strobe moves to the return stage
    a_r9_return_stage: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_v |=> st_q.ret_v);

    // R9: return stage produces a valid segment carrying the read address
    a_r9_seg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ret_v |=> (seg_valid_o && seg_addr_o == $past(st_q.ret_addr)));

endmodule

// File: rtl/hit_age_addresser.sv
module hit_age_addresser
    import hit_age_pkg::*;
#(
    parameter int unsigned N_WIRES = 8,
    parameter int unsigned AGE_W   = 2,
    parameter int unsigned WORD_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [N_WIRES-1:0]         hit_i,
    input  logic                       rehit_mode_i,
    output logic                       lut_rd_en_o,
    output logic [N_WIRES*AGE_W-1:0]   lut_addr_o,
    input  logic [WORD_W-1:0]          lut_rd_data_i,
    output logic                       seg_valid_o,
    output logic [N_WIRES*AGE_W-1:0]   seg_addr_o,
    output logic [WORD_W-1:0]          seg_word_o
);

    localparam int unsigned ADDR_W = N_WIRES * AGE_W;

    rehit_mode_e       mode;
    logic [ADDR_W-1:0] addr_vec;

    assign mode = rehit_mode_e'(rehit_mode_i);

    for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
        logic [AGE_W-1:0] age;

        hit_age_cell #(
            .AGE_W (AGE_W)
        ) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .hit_i  (hit_i[w]),
            .mode_i (mode),
            .age_o  (age)
        );

        assign addr_vec[w*AGE_W +: AGE_W] = age;
    end

    assign lut_addr_o = addr_vec;

    lut_read_pipe #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) pipe_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .addr_i      (addr_vec),
        .rd_en_o     (lut_rd_en_o),
        .rd_data_i   (lut_rd_data_i),
        .seg_valid_o (seg_valid_o),
        .seg_addr_o  (seg_addr_o),
        .seg_word_o  (seg_word_o)
    );

    // R8: every tick issues a read in the next clock
    a_r8_read_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> lut_rd_en_o);

    // R8: no tick, no read
    a_r8_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !lut_rd_en_o);

    // R4: address frozen between ticks
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(lut_addr_o));

endmodule

// File: tb/hit_age_addresser_tb_top.sv
`timescale 1ns/1ps
module hit_age_addresser_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [7:0]  hit_i = '0;
    logic        rehit_mode_i = 1'b0;
    logic        lut_rd_en_o;
    logic [15:0] lut_addr_o;
    logic [15:0] lut_rd_data_i = '0;
    logic        seg_valid_o;
    logic [15:0] seg_addr_o;
    logic [15:0] seg_word_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hit_age_addresser dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .hit_i         (hit_i),
        .rehit_mode_i  (rehit_mode_i),
        .lut_rd_en_o   (lut_rd_en_o),
        .lut_addr_o    (lut_addr_o),
        .lut_rd_data_i (lut_rd_data_i),
        .seg_valid_o   (seg_valid_o),
        .seg_addr_o    (seg_addr_o),
        .seg_word_o    (seg_word_o)
    );

    function automatic logic [15:0] lutf(input logic [15:0] a);
        logic [31:0] p;
        p = a * 32'h9E37;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    // behavioural lookup memory, one clock read latency
    always @(posedge clk) begin
        if (lut_rd_en_o) lut_rd_data_i <= lutf(lut_addr_o);
    end

    // reference model
    int          m_age[8];
    bit          m_rd_v, m_ret_v, m_seg_v;
    logic [15:0] m_addr, m_ret_addr, m_seg_addr, m_seg_word;

    function automatic logic [15:0] pack_ages();
        logic [15:0] a = '0;
        for (int i = 0; i < 8; i++) a[2*i +: 2] = m_age[i][1:0];
        return a;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_age[i] = 3;
            m_addr = 16'hFFFF;
            m_rd_v = 0; m_ret_v = 0; m_seg_v = 0;
            m_ret_addr = '0; m_seg_addr = '0; m_seg_word = '0;
        end else begin
            m_seg_v = m_ret_v;
            if (m_ret_v) begin
                m_seg_addr = m_ret_addr;
                m_seg_word = lutf(m_ret_addr);
            end
            m_ret_v = m_rd_v;
            if (m_rd_v) m_ret_addr = m_addr;
            m_rd_v = tick_i;
            if (tick_i) begin
                for (int i = 0; i < 8; i++) begin
                    if (hit_i[i] && (rehit_mode_i == 1'b0 || m_age[i] == 3)) m_age[i] = 0;
                    else if (m_age[i] < 3) m_age[i] = m_age[i] + 1;
                end
                m_addr = pack_ages();
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 read strobe", 32'(lut_rd_en_o), 32'(m_rd_v));
            chk("R7 address", 32'(lut_addr_o), 32'(m_addr));
            chk("R9 seg valid", 32'(seg_valid_o), 32'(m_seg_v));
            if (m_seg_v) begin
                chk("R9 seg addr", 32'(seg_addr_o), 32'(m_seg_addr));
                chk("R9 seg word", 32'(seg_word_o), 32'(m_seg_word));
            end
        end
    end

    task automatic step(input bit t, input logic [7:0] h);
        tick_i = t;
        hit_i  = h;
        @(posedge clk);
        @(negedge clk);
        tick_i = 1'b0;
        hit_i  = '0;
    endtask

    function automatic logic [31:0] fld(input int w);
        return 32'(lut_addr_o[2*w +: 2]);
    endfunction

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        done = 1;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 addr in reset", 32'(lut_addr_o), 32'hFFFF);
        chk("R1 rd_en in reset", 32'(lut_rd_en_o), 0);
        chk("R1 seg_valid in reset", 32'(seg_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 addr after reset", 32'(lut_addr_o), 32'hFFFF);

        // R2 fresh hit on wire 0, restart mode
        rehit_mode_i = 1'b0;
        step(1, 8'h01);
        chk("R2 wire0 age", fld(0), 0);
        chk("R7 packing wire0 low", 32'(lut_addr_o), 32'hFFFC);

        // R3 quiet ticks count up and saturate
        step(1, 8'h00); chk("R3 age1", fld(0), 1);
        step(1, 8'h00); chk("R3 age2", fld(0), 2);
        step(1, 8'h00); chk("R3 age3", fld(0), 3);
        step(1, 8'h00); chk("R3 saturated", fld(0), 3);

        // R7 wire 7 sits in the top pair
        step(1, 8'h80);
        chk("R7 packing wire7 high", 32'(lut_addr_o), 32'h3FFF);

        // R4 hit without tick is ignored
        step(0, 8'h04);
        chk("R4 wire2 unchanged", fld(2), 3);
        chk("R4 wire7 held", fld(7), 0);
        chk("R4 no read", 32'(lut_rd_en_o), 0);

        // R5 restart rule
        step(1, 8'h02); chk("R5 first hit", fld(1), 0);
        step(1, 8'h00); chk("R5 aged", fld(1), 1);
        step(1, 8'h02); chk("R5 rehit restarts", fld(1), 0);

        // R6 keep-older rule
        rehit_mode_i = 1'b1;
        step(1, 8'h08); chk("R6 fresh hit", fld(3), 0);
        step(1, 8'h00); chk("R6 aged", fld(3), 1);
        step(1, 8'h08); chk("R6 rehit ignored", fld(3), 2);
        step(1, 8'h08); chk("R6 rehit ignored again", fld(3), 3);
        step(1, 8'h08); chk("R6 idle wire restarts", fld(3), 0);

        // R9 seg output for a read
        step(0, 8'h00);
        step(0, 8'h00);
        chk("R9 seg addr after read", 32'(seg_addr_o), 32'(lut_addr_o));

        // random phase
        for (int c = 0; c < 3000; c++) begin
            logic [7:0] h;
            if (c % 250 == 0) rehit_mode_i = ~rehit_mode_i;
            for (int b = 0; b < 8; b++) h[b] = (($urandom % 6) == 0);
            step((($urandom % 5) != 0), h);
        end
        step(0, 8'h00);
        step(0, 8'h00);
        done = 1;
        report();
    end

endmodule